// File: doc/BRIEF.md
# Double-Buffered Serial Output Shifter

The block sends bytes out of a single serial line. It has a one-byte holding stage in front of a frame shifter. Software, or an upstream controller, writes a byte into the holding stage. On a later bit tick the shifter takes that byte and sends it as a 10-bit frame. The bit rate comes only from the `tick` strobe. No receiver can stall the line, so a frame always ends a fixed number of ticks after it starts.

Two status outputs go to an interrupt controller:
- `tx_ready` is a one-cycle event. It fires only when a byte moves from the holding stage into the shifter, so it does not fire when the last byte ends with nothing queued.
- `tx_done` is a plain level. It is high whenever the shifter is idle and needs no acknowledge.

Software keeps one byte queued ahead of the shifter, and back-to-back frames then leave with no gap.

The shifter state machine has four states:
- IDLE: the line is high and `tx_done` is high.
- START: the line sends 0.
- DATA: the line sends the shift register LSB. A bit counter runs from 0 to DATA_W-1.
- STOP: the line sends 1.

The transitions all happen on a cycle where `tick` is high:
- LOAD_IDLE (IDLE to START): a byte is queued.
- BEGIN_DATA (START to DATA).
- NEXT_BIT (DATA to DATA): the counter is below DATA_W-1.
- END_DATA (DATA to STOP): the counter equals DATA_W-1.
- CHAIN (STOP to START): a byte is queued.
- FINISH (STOP to IDLE): nothing is queued.

In every state, a cycle without a tick keeps the state.

Top module: `serial_out_dbuf`

## Requirements
- R1: After reset, `txd` is 1, `tx_done` is 1 and `tx_ready` is 0.
- R2: A write while the shifter is idle does not start a frame by itself. Until the next tick, `tx_done` stays 1, `txd` stays 1 and `tx_ready` stays 0.
- R3: On a tick edge where the shifter is idle and a byte is queued, the byte is transferred. In the cycle that follows, `tx_ready` is 1 for exactly one cycle, `tx_done` is 0 and `txd` is 0 (the start bit).
- R4: A frame is a start bit of 0, then 8 data bits with the LSB first, then a stop bit of 1. Each bit lasts one tick period. The idle line is 1.
- R5: `txd` changes only in the cycle after a clock edge on which `tick` was high.
- R6: The unsent flag clears at the moment of transfer. A byte written while the previous byte is shifting is held and sent as the next frame.
- R7: If a byte is queued at the tick that ends a stop bit, the next start bit begins at that same tick. `tx_done` does not go high between the two frames.
- R8: `tx_ready` pulses once per transfer. It does not pulse when the last frame ends with nothing queued.
- R9: `tx_done` is high exactly while the shifter is idle. It stays high for any length of time without an acknowledge and changes only after a tick edge.
- R10: A write while the holding stage is already full replaces the queued byte. Only the newest byte is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Bit-rate strobe, one cycle wide |
| wr_en | input | 1 | Write strobe for the holding stage |
| wr_data | input | 8 | Byte to queue |
| txd | output | 1 | Serial data line |
| tx_ready | output | 1 | One-cycle event: a byte moved into the shifter |
| tx_done | output | 1 | Level: the shifter is idle |

## Verification
Two cases are hard to reach from the ports:
- The overwrite case needs two writes during one frame. Both must come after that frame's transfer and before its stop bit ends. The stimulus waits for the `tx_ready` event of the running frame and then writes twice in a row.
- The gapless chain needs a byte queued at the exact tick that ends a stop bit. The stimulus writes the next byte right after the first transfer. A watcher then records whether `tx_done` ever rises before the second frame has been received.

A scoreboard rebuilds every frame from the line at the tick instants and compares it with the bytes expected in order.

// File: rtl/sotx_pkg.sv
package sotx_pkg;
    typedef enum logic [1:0] {
        SH_IDLE  = 2'd0,
        SH_START = 2'd1,
        SH_DATA  = 2'd2,
        SH_STOP  = 2'd3
    } sh_state_t;

    localparam int START_LVL = 0;
    localparam int STOP_LVL  = 1;
endpackage

// File: rtl/sotx_hold_buf.sv
module sotx_hold_buf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data
);
    // A write in the same cycle as a take queues the new byte; the take
    // consumes the byte that was held before the edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
        end else begin
            if (wr_en) begin
                data <= wr_data;
                full <= 1'b1;
            end else if (take) begin
                full <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sotx_bit_counter.sv
module sotx_bit_counter #(
    parameter int DATA_W = 8,
    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(DATA_W - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= (cnt == LAST_VAL) ? '0 : cnt + 1'b1;
        end
    end

    assign last = (cnt == LAST_VAL);
endmodule

// File: rtl/sotx_shift_fsm.sv
module sotx_shift_fsm
    import sotx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              hold_full,
    input  logic [DATA_W-1:0] hold_data,
    input  logic              cnt_last,
    output logic              take,
    output logic              cnt_inc,
    output logic              txd,
    output logic              ready_evt,
    output logic              idle
);
    sh_state_t         st, st_nxt;
    logic [DATA_W-1:0] shreg;

    // State register, shift register and event register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= SH_IDLE;
            shreg     <= '0;
            ready_evt <= 1'b0;
        end else begin
            st        <= st_nxt;
            ready_evt <= take;
            if (take) begin
                shreg <= hold_data;
            end else if (cnt_inc) begin
                shreg <= shreg >> 1;
            end
        end
    end

    // Next state and control strobes
    always_comb begin
        st_nxt  = st;
        take    = 1'b0;
        cnt_inc = 1'b0;
        unique case (st)
            SH_IDLE: begin
                if (tick && hold_full) begin
                    take   = 1'b1;
                    st_nxt = SH_START;
                end
            end
            SH_START: begin
                if (tick) begin
                    st_nxt = SH_DATA;
                end
            end
            SH_DATA: begin
                if (tick) begin
                    cnt_inc = 1'b1;
                    if (cnt_last) begin
                        st_nxt = SH_STOP;
                    end
                end
            end
            SH_STOP: begin
                if (tick) begin
                    if (hold_full) begin
                        take   = 1'b1;
                        st_nxt = SH_START;
                    end else begin
                        st_nxt = SH_IDLE;
                    end
                end
            end
            default: st_nxt = SH_IDLE;
        endcase
    end

    // Line and idle decode from the state register
    always_comb begin
        txd  = 1'b1;
        idle = 1'b0;
        unique case (st)
            SH_IDLE:  begin txd = 1'b1; idle = 1'b1; end
            SH_START: txd = 1'(START_LVL);
            SH_DATA:  txd = shreg[0];
            SH_STOP:  txd = 1'(STOP_LVL);
            default:  begin txd = 1'b1; idle = 1'b1; end
        endcase
    end
endmodule

// File: rtl/serial_out_dbuf.sv
module serial_out_dbuf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              txd,
    output logic              tx_ready,
    output logic              tx_done
);
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              take;
    logic              cnt_inc;
    logic              cnt_last;

    sotx_hold_buf #(.DATA_W(DATA_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .take    (take),
        .full    (hold_full),
        .data    (hold_data)
    );

    sotx_bit_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (take),
        .inc   (cnt_inc),
        .last  (cnt_last)
    );

    sotx_shift_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .hold_full (hold_full),
        .hold_data (hold_data),
        .cnt_last  (cnt_last),
        .take      (take),
        .cnt_inc   (cnt_inc),
        .txd       (txd),
        .ready_evt (tx_ready),
        .idle      (tx_done)
    );
endmodule

// File: rtl/sotx_checker.sv
module sotx_checker (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic txd,
    input logic tx_ready,
    input logic tx_done
);
    // R3: the ready event follows a tick edge
    assert_ready_after_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> $past(tick));

    // R3: the ready event lasts one cycle
    assert_ready_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |=> !tx_ready);

    // R4: the line is high while idle
    assert_idle_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> txd);

    // R5: the line moves only after a tick edge
    assert_txd_rate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tick) |-> $stable(txd));

    // R8: a transfer starts a frame, so the ready event never comes while idle
    assert_ready_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> (!tx_done && !txd));

    // R9: the idle level changes only after a tick edge
    assert_done_rate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tick) |-> $stable(tx_done));
endmodule

bind serial_out_dbuf sotx_checker u_sotx_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .txd      (txd),
    .tx_ready (tx_ready),
    .tx_done  (tx_done)
);

// File: tb/test_serial_out_dbuf.sv
module test_serial_out_dbuf;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       txd, tx_ready, tx_done;

    int n_cmp = 0;
    int n_bad = 0;
    int rdy_cnt = 0;
    int frames = 0;
    bit tick_auto = 1'b0;
    bit gap_watch = 1'b0;
    bit gap_seen = 1'b0;
    bit done_flag = 1'b0;
    logic [7:0] exp_q[$];

    always #5 clk = ~clk;

    serial_out_dbuf i_serial_out_dbuf (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .wr_data(wr_data), .txd(txd), .tx_ready(tx_ready), .tx_done(tx_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Driver: queue a byte and record the expected frame
    task automatic send(input logic [7:0] b, input bit replace);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = b;
        if (replace && exp_q.size() > 0) void'(exp_q.pop_back());
        exp_q.push_back(b);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Automatic tick generator: one tick every 4 cycles
    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            if (tick_auto) begin
                tick = (ph == 3);
                ph = (ph + 1) % 4;
            end
        end
    end

    // Monitor: rebuild frames at tick instants and compare with the queue
    initial begin
        logic [9:0] fr;
        int bc = 0;
        forever begin
            @(posedge clk);
            if (rst_n && tick) begin
                #1;
                if (!tx_done) begin
                    fr[bc] = txd;
                    bc++;
                    if (bc == 10) begin
                        logic [7:0] e;
                        bc = 0;
                        frames++;
                        chk(fr[0] == 1'b0, "R4 start bit", fr[0], 0);
                        chk(fr[9] == 1'b1, "R4 stop bit", fr[9], 1);
                        if (exp_q.size() == 0) begin
                            chk(1'b0, "R4 unexpected frame", fr[8:1], 0);
                        end else begin
                            e = exp_q.pop_front();
                            chk(fr[8:1] == e, "R4 data LSB first", fr[8:1], e);
                        end
                    end
                end
            end
        end
    end

    // Event counter and gap watcher
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && tx_ready) rdy_cnt++;
            if (gap_watch && tx_done) gap_seen = 1'b1;
        end
    end

    initial begin
        #2000000;
        if (!done_flag) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(txd == 1'b1, "R1 txd", txd, 1);
        chk(tx_done == 1'b1, "R1 done", tx_done, 1);
        chk(tx_ready == 1'b0, "R1 ready", tx_ready, 0);

        // R2: a write alone does not start the frame
        send(8'hA5, 1'b0);
        repeat (5) @(negedge clk);
        chk(tx_done == 1'b1 && txd == 1'b1 && tx_ready == 1'b0, "R2 waits for tick",
            {tx_done, txd, tx_ready}, 3'b110);

        // R3: a manual tick transfers the byte
        @(negedge clk);
        tick = 1'b1;
        @(posedge clk);
        #1;
        chk(tx_ready == 1'b1, "R3 ready pulse", tx_ready, 1);
        chk(tx_done == 1'b0, "R3 done low", tx_done, 0);
        chk(txd == 1'b0, "R3 start bit", txd, 0);
        @(negedge clk);
        tick = 1'b0;
        @(posedge clk);
        #1;
        chk(tx_ready == 1'b0, "R3 one cycle", tx_ready, 0);

        // R6 and R7: queue the next byte right after the transfer, expect no gap
        gap_watch = 1'b1;
        send(8'h3C, 1'b0);
        tick_auto = 1'b1;
        wait (frames == 2);
        gap_watch = 1'b0;
        chk(gap_seen == 1'b0, "R7 no gap between frames", gap_seen, 0);
        chk(rdy_cnt == 2, "R6 second byte transferred", rdy_cnt, 2);

        // R8 and R9: no event at the end, and the idle level holds
        repeat (60) @(negedge clk);
        chk(rdy_cnt == 2, "R8 no ready at end", rdy_cnt, 2);
        chk(tx_done == 1'b1 && txd == 1'b1, "R9 idle level held", {tx_done, txd}, 2'b11);

        // R10: overwrite the queued byte while a frame is shifting
        send(8'h11, 1'b0);
        wait (rdy_cnt == 3);
        send(8'h22, 1'b0);
        send(8'h33, 1'b1);
        wait (frames == 4);
        repeat (60) @(negedge clk);
        chk(rdy_cnt == 4, "R10 one transfer for overwritten slot", rdy_cnt, 4);
        chk(exp_q.size() == 0, "R10 all expected frames seen", exp_q.size(), 0);

        // Stream of edge patterns, kept one byte ahead
        send(8'h00, 1'b0);
        send(8'hFF, 1'b1);
        send(8'hFF, 1'b1);
        exp_q.delete();
        exp_q.push_back(8'hFF);
        wait (rdy_cnt == 5);
        send(8'h80, 1'b0);
        wait (rdy_cnt == 6);
        send(8'h01, 1'b0);
        wait (frames == 7);
        repeat (60) @(negedge clk);
        chk(rdy_cnt == 7, "R8 ready count equals frames", rdy_cnt, 7);
        chk(tx_done == 1'b1, "R9 idle after stream", tx_done, 1);

        done_flag = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule